// File: doc/BRIEF.md
# Successive-Approximation Multiplier Divider

This block divides one unsigned word by another. It does not subtract shifted copies of the divisor from a partial remainder. It runs a binary search over the quotient instead, from the top bit down. On each step it proposes a quotient with one more bit set. A multiplier forms the product of that trial value and the divisor, and a comparator checks the product against the dividend. The bit stays set only when the product does not pass the dividend. Every bit gets exactly one step, so the latency is fixed and does not depend on the operands.

A client raises `start` while the block is idle. It reads the results when `done` goes high. The operands are captured when the operation is accepted. The results stay on the outputs until the next operation finishes. A zero divisor does not abort the run. It completes in the same time and reports through a flag.

Top module: `sa_divider`

## Requirements
- R1: A `start` seen while `busy` is low is accepted. `busy` is high from the following cycle, and the first trial quotient has only its most significant bit set.
- R2: Each busy cycle settles one quotient bit, highest first. The bit is kept only if trial quotient × divisor, formed at double width, is not greater than the dividend. The final quotient equals floor(dividend / divisor).
- R3: At completion, `remainder` equals dividend − quotient × divisor, and it is smaller than a nonzero divisor.
- R4: `done` rises exactly W clock cycles after the accepting edge, for any operands. `busy` and `done` are never high together.
- R5: A zero divisor sets `div_by_zero`, drives `quotient` to all ones and gives `remainder` = dividend. The next operation with a nonzero divisor clears the flag.
- R6: While `busy` is high, `start` and any change on `dividend` or `divisor` have no effect on the running operation or on its latency.
- R7: Once `done` is high, it stays high and `quotient`, `remainder` and `div_by_zero` stay unchanged until a new operation completes. `done` falls at the edge that accepts the next `start`.
- R8: After reset, `busy`, `done` and `div_by_zero` are low, and `quotient` and `remainder` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a division; honoured only when idle |
| dividend | input | W | Unsigned dividend, captured on acceptance |
| divisor | input | W | Unsigned divisor, captured on acceptance |
| busy | output | 1 | A division is in progress |
| done | output | 1 | Results are valid; held until next acceptance |
| quotient | output | W | Unsigned quotient |
| remainder | output | W | Unsigned remainder |
| div_by_zero | output | 1 | The last completed division had a zero divisor |

## Verification
The table of operand pairs covers several cases. A quotient of zero (dividend below divisor) shows that every trial bit gets cleared. A divisor of one, with the largest dividend, shows that every bit is kept. Equal operands and a divisor of two show a single surviving bit and a lone shifted pattern. Mixed pairs with nonzero remainders check that keep and clear decisions work together and that the remainder subtraction is correct. The directed tests measure latency at both extremes of the data. They also re-pulse `start` with new operands mid-run to tell an ignored request from a restart, then change the inputs after completion to show the outputs are held.

// File: rtl/sa_div_pkg.sv
package sa_div_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } div_state_e;
endpackage

// File: rtl/sa_div_ctrl.sv
module sa_div_ctrl
  import sa_div_pkg::*;
#(
  parameter int W  = 32,
  localparam int CW = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          accept,
  output logic          last,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] bit_idx
);

  div_state_e state_q;
  logic [CW-1:0] cnt_q;
  logic done_q;

  assign busy    = (state_q == ST_RUN);
  assign accept  = start && !busy;
  assign last    = busy && (cnt_q == '0);
  assign bit_idx = cnt_q;
  assign done    = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else if (accept) begin
      state_q <= ST_RUN;
      cnt_q   <= CW'(W - 1);
      done_q  <= 1'b0;
    end else if (last) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b1;
    end else if (busy) begin
      cnt_q   <= cnt_q - CW'(1);
    end
  end

endmodule

// File: rtl/sa_div_trial.sv
module sa_div_trial #(
  parameter int W  = 32,
  localparam int CW = (W > 1) ? $clog2(W) : 1,
  localparam int PW = 2 * W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          busy,
  input  logic [CW-1:0] bit_idx,
  input  logic [W-1:0]  dividend,
  input  logic [W-1:0]  divisor,
  output logic [W-1:0]  op_a,
  output logic [W-1:0]  op_b,
  output logic [W-1:0]  trial_q,
  output logic          keep,
  output logic [W-1:0]  next_q
);

  // Trial product never overflows: it is formed at double width.
  function automatic logic trial_fits(input logic [W-1:0] q,
                                      input logic [W-1:0] b,
                                      input logic [W-1:0] a);
    logic [PW-1:0] prod;
    prod = PW'(q) * PW'(b);
    return prod <= PW'(a);
  endfunction

  logic [CW-1:0] idx_below;

  assign keep      = trial_fits(trial_q, op_b, op_a);
  assign idx_below = bit_idx - CW'(1);

  always_comb begin
    next_q = trial_q;
    if (!keep) next_q[bit_idx] = 1'b0;
    if (bit_idx != '0) next_q[idx_below] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_a    <= '0;
      op_b    <= '0;
      trial_q <= '0;
    end else if (accept) begin
      op_a    <= dividend;
      op_b    <= divisor;
      trial_q <= {1'b1, {(W-1){1'b0}}};
    end else if (busy) begin
      trial_q <= next_q;
    end
  end

endmodule

// File: rtl/sa_divider.sv
module sa_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         div_by_zero
);

  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam int PW = 2 * W;

  function automatic logic [W-1:0] rem_of(input logic [W-1:0] a,
                                          input logic [W-1:0] b,
                                          input logic [W-1:0] q);
    logic [PW-1:0] prod;
    prod = PW'(q) * PW'(b);
    return a - prod[W-1:0];
  endfunction

  logic          accept;
  logic          last;
  logic [CW-1:0] bit_idx;
  logic [W-1:0]  op_a;
  logic [W-1:0]  op_b;
  logic [W-1:0]  trial_q;
  logic          keep;
  logic [W-1:0]  next_q;
  logic          zero_div;

  logic [W-1:0]  quot_q;
  logic [W-1:0]  rem_q;
  logic          dbz_q;

  sa_div_ctrl #(.W(W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .accept  (accept),
    .last    (last),
    .busy    (busy),
    .done    (done),
    .bit_idx (bit_idx)
  );

  sa_div_trial #(.W(W)) u_trial (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .busy     (busy),
    .bit_idx  (bit_idx),
    .dividend (dividend),
    .divisor  (divisor),
    .op_a     (op_a),
    .op_b     (op_b),
    .trial_q  (trial_q),
    .keep     (keep),
    .next_q   (next_q)
  );

  assign zero_div = (op_b == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quot_q <= '0;
      rem_q  <= '0;
      dbz_q  <= 1'b0;
    end else if (last) begin
      quot_q <= zero_div ? {W{1'b1}} : next_q;
      rem_q  <= zero_div ? op_a : rem_of(op_a, op_b, next_q);
      dbz_q  <= zero_div;
    end
  end

  assign quotient    = quot_q;
  assign remainder   = rem_q;
  assign div_by_zero = dbz_q;

endmodule

// File: rtl/sa_divider_chk.sv
module sa_divider_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic         accept,
  input logic         last,
  input logic [W-1:0] trial_q,
  input logic [W-1:0] op_b,
  input logic [W-1:0] quotient,
  input logic [W-1:0] remainder,
  input logic         div_by_zero
);

  logic [15:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_cnt <= '0;
    else if (accept) run_cnt <= '0;
    else if (busy)   run_cnt <= run_cnt + 16'd1;
  end

  a_r1_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  a_r1_msb_seed: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (trial_q == {1'b1, {(W-1){1'b0}}}));

  a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> (run_cnt == 16'(W - 1)));

  a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  a_r3_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && !div_by_zero) |-> (remainder < op_b));

  a_r5_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && div_by_zero) |-> (&quotient));

  a_r6_ignore_start: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !last) |=> busy);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ($stable(quotient) && $stable(remainder) && $stable(div_by_zero)));

endmodule

bind sa_divider sa_divider_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .busy        (busy),
  .done        (done),
  .accept      (accept),
  .last        (last),
  .trial_q     (trial_q),
  .op_b        (op_b),
  .quotient    (quotient),
  .remainder   (remainder),
  .div_by_zero (div_by_zero)
);

// File: tb/tb_sa_divider.sv
`timescale 1ns/1ps
module tb_sa_divider;
  localparam int W = 32;
  localparam int NV = 10;

  // {dividend, divisor}
  localparam logic [63:0] VEC [NV] = '{
    {32'd100,        32'd7},
    {32'd0,          32'd5},
    {32'd5,          32'd100},
    {32'hFFFF_FFFF,  32'd1},
    {32'hFFFF_FFFF,  32'hFFFF_FFFF},
    {32'hFFFF_FFFF,  32'd2},
    {32'd12345678,   32'd1},
    {32'h8000_0000,  32'd3},
    {32'd1000,       32'd1000},
    {32'hDEAD_BEEF,  32'h0000_1234}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         busy, done, div_by_zero;
  logic [W-1:0] quotient, remainder;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  sa_divider #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
    .divisor(divisor), .busy(busy), .done(done), .quotient(quotient),
    .remainder(remainder), .div_by_zero(div_by_zero)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Starts an operation at a negedge, returns cycles until done seen.
  task automatic run_div(input logic [W-1:0] a, input logic [W-1:0] b, output int cyc);
    @(negedge clk);
    dividend = a; divisor = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R1 busy after accept", W'(busy), W'(1));
    chk("R7 done falls on accept", W'(done), W'(0));
    cyc = 0;
    while (!done && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int cyc;
    logic [W-1:0] hq, hr;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 busy", W'(busy), W'(0));
    chk("R8 done", W'(done), W'(0));
    chk("R8 quotient", quotient, '0);
    chk("R8 remainder", remainder, '0);
    chk("R8 dbz", W'(div_by_zero), W'(0));
    rst_n = 1'b1;

    // R2 R3 R4 table
    for (int i = 0; i < NV; i++) begin
      logic [W-1:0] a, b;
      a = VEC[i][63:32];
      b = VEC[i][31:0];
      run_div(a, b, cyc);
      chk("R4 latency", W'(cyc), W'(W));
      chk("R2 quotient", quotient, a / b);
      chk("R3 remainder", remainder, a % b);
      chk("R5 flag clear", W'(div_by_zero), W'(0));
    end

    // R5 zero divisor
    run_div(32'h1234_5678, 32'd0, cyc);
    chk("R5 latency", W'(cyc), W'(W));
    chk("R5 flag", W'(div_by_zero), W'(1));
    chk("R5 quotient", quotient, 32'hFFFF_FFFF);
    chk("R5 remainder", remainder, 32'h1234_5678);

    // R7 hold after done while inputs move
    hq = quotient; hr = remainder;
    dividend = 32'd77; divisor = 32'd3;
    repeat (6) @(negedge clk);
    chk("R7 done held", W'(done), W'(1));
    chk("R7 quotient held", quotient, hq);
    chk("R7 remainder held", remainder, hr);
    chk("R7 flag held", W'(div_by_zero), W'(1));

    // R6 start and operand change while busy are ignored
    @(negedge clk);
    dividend = 32'd1000; divisor = 32'd7; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    repeat (5) begin @(negedge clk); cyc++; end
    dividend = 32'd9; divisor = 32'd3; start = 1'b1;
    @(negedge clk); cyc++;
    start = 1'b0;
    dividend = 32'd55;
    while (!done && cyc < 100) begin @(negedge clk); cyc++; end
    chk("R6 latency unchanged", W'(cyc), W'(W));
    chk("R6 quotient", quotient, 32'd142);
    chk("R6 remainder", remainder, 32'd6);
    chk("R5 flag cleared", W'(div_by_zero), W'(0));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule